// File: doc/BRIEF.md
# Indexed Pixel Stream with Hardware Cursor Overlay

This block turns a byte-per-pixel frame held in video memory into a stream of 24-bit RGB pixels. On a start pulse it takes a snapshot of the frame geometry and display controls, then walks the visible area row by row. It fetches one colour index per pixel through a simple read port whose data arrives one cycle after the request. The port starts at a programmable top-of-screen byte offset and steps by one byte for every pixel. Lines are packed with no padding, so the line pitch equals the width.

Each index is looked up in a 256-entry colour table. Over the base picture lies a 64x64 cursor whose pattern holds two bits per pixel. A code of zero lets the base picture show through, and the other three codes pick one of three cursor colours. A force-blank control turns every pixel black while keeping the stream timing. A cursor-disable control removes the cursor altogether.

The colour table, the cursor colours and the cursor pattern are loaded through write ports. The output carries valid, end-of-line and end-of-frame markers, and the end-of-frame pulse is suited to drive a frame interrupt. Sync timing and memory arbitration are handled elsewhere.

Top module: `idxCursorPixelPath`

## Requirements
- R1: After `frameGo` with non-zero width W and height H, the block issues exactly W*H reads at consecutive byte addresses top, top+1, ..., top+W*H-1 and emits exactly W*H valid pixels in raster order (left to right, then top to bottom).
- R2: Outside the cursor, and when not blanked, a pixel's RGB equals the colour-table entry selected by its video byte. In `palRgb` and all RGB values, bits 23:16 are red, 15:8 green and 7:0 blue.
- R3: `pixEol` is high exactly on the pixel at column W-1 of every row. `pixEof` is high exactly once per frame, on the final pixel of row H-1, together with `pixEol`.
- R4: A `frameGo` while the sampled width or height is zero issues no read and produces no valid pixel.
- R5: `cfgCursorPos` bits 23:12 give the cursor's left column X and bits 11:0 its top row Y. A pixel (x,y) lies in the cursor when X <= x < X+64 and Y <= y < Y+64.
- R6: For a cursor pixel with offsets dx=x-X and dy=y-Y, the pattern word index is dy*8 + dx/8. The pixel's 2-bit code is word bits [2k+1:2k], where k = dx mod 8, so bits 1:0 hold the leftmost pixel of the word.
- R7: Cursor code 0 shows the colour-table colour. Codes 1, 2 and 3 show cursor colour entries 0, 1 and 2, which are written at `cpalIdx` 0, 1 and 2.
- R8: With `cfgCursorOff` set at frame start, no pixel is treated as part of the cursor.
- R9: With `cfgBlank` set at frame start, every pixel is 0x000000, with the same count and markers as an unblanked frame.
- R10: The first valid pixel appears two cycles after its read is issued, and with the memory always ready the pixels of a frame are valid on consecutive cycles with no gaps.
- R11: Geometry, top offset, cursor position and the controls are sampled at the accepted `frameGo`. A `frameGo` or a configuration change during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameGo | input | 1 | Start-of-frame pulse |
| cfgWidth | input | DIM_W | Visible width in pixels |
| cfgHeight | input | DIM_W | Visible height in lines |
| cfgTop | input | ADDR_W | Byte offset of the first pixel |
| cfgCursorPos | input | 24 | Cursor X in 23:12, Y in 11:0 |
| cfgCursorOff | input | 1 | Disable the cursor overlay |
| cfgBlank | input | 1 | Force all pixels black |
| palWe | input | 1 | Colour table write strobe |
| palIdx | input | 8 | Colour table entry |
| palRgb | input | 24 | Colour table data |
| cpalWe | input | 1 | Cursor colour write strobe |
| cpalIdx | input | 2 | Cursor colour entry (0..2) |
| cpalRgb | input | 24 | Cursor colour data |
| patWe | input | 1 | Cursor pattern write strobe |
| patIdx | input | 9 | Cursor pattern word index |
| patWord | input | 16 | Cursor pattern word |
| memRdEn | output | 1 | Video memory read request |
| memRdAddr | output | ADDR_W | Video memory byte address |
| memRdData | input | 8 | Read data, one cycle after the request |
| pixValid | output | 1 | Pixel valid |
| pixRgb | output | 24 | Pixel colour |
| pixEol | output | 1 | Last pixel of a line |
| pixEof | output | 1 | Last pixel of the frame |

## Verification
Every cycle, the assertions check several properties. Read addresses step by exactly one inside a frame, and a start request with a zero dimension issues no read. A frame marker never appears without a line marker. A valid pixel leaves the colour stage one cycle after its strobe, and nothing is valid without one. A blanked pixel is black. Whether the pixel values are right is a different matter: correct colour lookup, pattern-word selection, cursor clipping at the frame edges, the number of pixels and the sampling of the configuration at frame start can only be shown by the bench's scenarios. These compare every pixel against an independent model of video memory and tables.

// File: rtl/pixOverlayPkg.sv
package pixOverlayPkg;
  localparam int CUR_LOG2 = 6;                  // cursor is 2^6 = 64 pixels square
  localparam int CUR_SIZE = 1 << CUR_LOG2;
  localparam int PAT_AW   = 2 * CUR_LOG2 - 3;   // 8 two-bit pixels per 16-bit word
  localparam int PAT_DEPTH = 1 << PAT_AW;
  localparam int RGB_W    = 24;

  typedef enum logic [0:0] {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scanState_t;

  typedef struct packed {
    logic              valid;
    logic              eol;
    logic              eof;
    logic              blank;
    logic              hit;
    logic [PAT_AW-1:0] patIdx;
    logic [2:0]        sub;
  } pixStrobe_t;
endpackage

// File: rtl/pixScanCtrl.sv
module pixScanCtrl
  import pixOverlayPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameGo,
  input  logic [DIM_W-1:0]  cfgWidth,
  input  logic [DIM_W-1:0]  cfgHeight,
  input  logic [ADDR_W-1:0] cfgTop,
  input  logic [23:0]       cfgCursorPos,
  input  logic              cfgCursorOff,
  input  logic              cfgBlank,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output pixStrobe_t        stOut
);
  localparam int POS_HALF = 12;

  scanState_t        state;
  logic [DIM_W-1:0]  widthLat, heightLat, xCnt, yCnt;
  logic [DIM_W-1:0]  curX, curY;
  logic              curOffLat, blankLat;
  logic [ADDR_W-1:0] addrCnt;

  logic              running, lastCol, lastRow, startOk;
  logic [DIM_W:0]    dx, dy;
  logic              inX, inY, hitNow;

  assign running = (state == SCAN_RUN);
  assign lastCol = (xCnt == widthLat - 1'b1);
  assign lastRow = (yCnt == heightLat - 1'b1);
  assign startOk = frameGo && (cfgWidth != '0) && (cfgHeight != '0);

  // Offsets into the cursor square; a borrow means left of / above it.
  assign dx  = {1'b0, xCnt} - {1'b0, curX};
  assign dy  = {1'b0, yCnt} - {1'b0, curY};
  assign inX = !dx[DIM_W] && (dx[DIM_W-1:CUR_LOG2] == '0);
  assign inY = !dy[DIM_W] && (dy[DIM_W-1:CUR_LOG2] == '0);
  assign hitNow = inX && inY && !curOffLat;

  assign memRdEn   = running;
  assign memRdAddr = addrCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SCAN_IDLE;
      widthLat  <= '0;
      heightLat <= '0;
      xCnt      <= '0;
      yCnt      <= '0;
      curX      <= '0;
      curY      <= '0;
      curOffLat <= 1'b1;
      blankLat  <= 1'b0;
      addrCnt   <= '0;
    end else begin
      case (state)
        SCAN_IDLE: begin
          if (startOk) begin
            state     <= SCAN_RUN;
            widthLat  <= cfgWidth;
            heightLat <= cfgHeight;
            xCnt      <= '0;
            yCnt      <= '0;
            curX      <= DIM_W'(cfgCursorPos[2*POS_HALF-1:POS_HALF]);
            curY      <= DIM_W'(cfgCursorPos[POS_HALF-1:0]);
            curOffLat <= cfgCursorOff;
            blankLat  <= cfgBlank;
            addrCnt   <= cfgTop;
          end
        end
        SCAN_RUN: begin
          addrCnt <= addrCnt + 1'b1;
          if (lastCol) begin
            xCnt <= '0;
            if (lastRow) state <= SCAN_IDLE;
            else         yCnt  <= yCnt + 1'b1;
          end else begin
            xCnt <= xCnt + 1'b1;
          end
        end
        default: state <= SCAN_IDLE;
      endcase
    end
  end

  // Strobes travel alongside the memory read so they meet its data.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stOut <= '0;
    end else begin
      stOut.valid  <= running;
      stOut.eol    <= running && lastCol;
      stOut.eof    <= running && lastCol && lastRow;
      stOut.blank  <= blankLat;
      stOut.hit    <= running && hitNow;
      stOut.patIdx <= {dy[CUR_LOG2-1:0], dx[CUR_LOG2-1:3]};
      stOut.sub    <= dx[2:0];
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn && $past(memRdEn) && !stOut.eof |-> memRdAddr == ADDR_W'($past(memRdAddr) + 1'b1)); // R1
  AST_ZERO_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!memRdEn && frameGo && (cfgWidth == '0 || cfgHeight == '0)) |=> !memRdEn); // R4
  AST_EOF_WITH_EOL: assert property (@(posedge clk) disable iff (!rstN)
    stOut.eof |-> stOut.eol && stOut.valid); // R3
endmodule

// File: rtl/pixColorDp.sv
module pixColorDp
  import pixOverlayPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pixStrobe_t        stIn,
  input  logic [7:0]        memRdData,
  input  logic              palWe,
  input  logic [7:0]        palIdx,
  input  logic [RGB_W-1:0]  palRgb,
  input  logic              cpalWe,
  input  logic [1:0]        cpalIdx,
  input  logic [RGB_W-1:0]  cpalRgb,
  input  logic              patWe,
  input  logic [PAT_AW-1:0] patIdx,
  input  logic [15:0]       patWord,
  output logic              pixValid,
  output logic [RGB_W-1:0]  pixRgb,
  output logic              pixEol,
  output logic              pixEof
);
  localparam int PAL_DEPTH  = 256;
  localparam int CPAL_COUNT = 3;

  logic [RGB_W-1:0] palMem [PAL_DEPTH];
  logic [15:0]      patMem [PAT_DEPTH];
  logic [RGB_W-1:0] curPal [CPAL_COUNT];

  logic [15:0]      patSel;
  logic [1:0]       code;
  logic [RGB_W-1:0] baseRgb, nextRgb;

  always_ff @(posedge clk) begin
    if (palWe) palMem[palIdx] <= palRgb;
  end

  always_ff @(posedge clk) begin
    if (patWe) patMem[patIdx] <= patWord;
  end

  generate
    for (genvar i = 0; i < CPAL_COUNT; i++) begin : gCurPal
      always_ff @(posedge clk) begin
        if (!rstN)                               curPal[i] <= '0;
        else if (cpalWe && cpalIdx == 2'(i))     curPal[i] <= cpalRgb;
      end
    end
  endgenerate

  assign patSel  = patMem[stIn.patIdx];
  assign code    = patSel[{stIn.sub, 1'b0} +: 2];
  assign baseRgb = palMem[memRdData];

  always_comb begin
    nextRgb = baseRgb;
    if (stIn.blank) begin
      nextRgb = '0;
    end else if (stIn.hit) begin
      case (code)
        2'd1:    nextRgb = curPal[0];
        2'd2:    nextRgb = curPal[1];
        2'd3:    nextRgb = curPal[2];
        default: nextRgb = baseRgb;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixValid <= 1'b0;
      pixRgb   <= '0;
      pixEol   <= 1'b0;
      pixEof   <= 1'b0;
    end else begin
      pixValid <= stIn.valid;
      pixRgb   <= stIn.valid ? nextRgb : '0;
      pixEol   <= stIn.eol;
      pixEof   <= stIn.eof;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    stIn.valid |=> pixValid); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !stIn.valid |=> !pixValid && !pixEol && !pixEof); // R10
  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rstN)
    stIn.valid && stIn.blank |=> pixRgb == '0); // R9
  AST_EOF_MARK: assert property (@(posedge clk) disable iff (!rstN)
    pixEof |-> pixEol && pixValid); // R3
endmodule

// File: rtl/idxCursorPixelPath.sv
module idxCursorPixelPath
  import pixOverlayPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameGo,
  input  logic [DIM_W-1:0]  cfgWidth,
  input  logic [DIM_W-1:0]  cfgHeight,
  input  logic [ADDR_W-1:0] cfgTop,
  input  logic [23:0]       cfgCursorPos,
  input  logic              cfgCursorOff,
  input  logic              cfgBlank,
  input  logic              palWe,
  input  logic [7:0]        palIdx,
  input  logic [23:0]       palRgb,
  input  logic              cpalWe,
  input  logic [1:0]        cpalIdx,
  input  logic [23:0]       cpalRgb,
  input  logic              patWe,
  input  logic [8:0]        patIdx,
  input  logic [15:0]       patWord,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  output logic              pixValid,
  output logic [23:0]       pixRgb,
  output logic              pixEol,
  output logic              pixEof
);
  pixStrobe_t strobe;

  pixScanCtrl #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .frameGo      (frameGo),
    .cfgWidth     (cfgWidth),
    .cfgHeight    (cfgHeight),
    .cfgTop       (cfgTop),
    .cfgCursorPos (cfgCursorPos),
    .cfgCursorOff (cfgCursorOff),
    .cfgBlank     (cfgBlank),
    .memRdEn      (memRdEn),
    .memRdAddr    (memRdAddr),
    .stOut        (strobe)
  );

  pixColorDp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stIn      (strobe),
    .memRdData (memRdData),
    .palWe     (palWe),
    .palIdx    (palIdx),
    .palRgb    (palRgb),
    .cpalWe    (cpalWe),
    .cpalIdx   (cpalIdx),
    .cpalRgb   (cpalRgb),
    .patWe     (patWe),
    .patIdx    (patIdx),
    .patWord   (patWord),
    .pixValid  (pixValid),
    .pixRgb    (pixRgb),
    .pixEol    (pixEol),
    .pixEof    (pixEof)
  );
endmodule

// File: tb/idxCursorPixelPath_tb_top.sv
`timescale 1ns/1ps
module idxCursorPixelPath_tb_top;
  localparam int ADDR_W = 20;
  localparam int DIM_W  = 12;
  localparam int VMEM   = 8192;
  localparam int MAXPIX = 8192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameGo = 1'b0;
  logic [DIM_W-1:0]  cfgWidth = '0, cfgHeight = '0;
  logic [ADDR_W-1:0] cfgTop = '0;
  logic [23:0] cfgCursorPos = '0;
  logic cfgCursorOff = 1'b1, cfgBlank = 1'b0;
  logic palWe = 1'b0, cpalWe = 1'b0, patWe = 1'b0;
  logic [7:0] palIdx = '0;
  logic [23:0] palRgb = '0, cpalRgb = '0;
  logic [1:0] cpalIdx = '0;
  logic [8:0] patIdx = '0;
  logic [15:0] patWord = '0;
  logic memRdEn;
  logic [ADDR_W-1:0] memRdAddr;
  logic [7:0] memRdData = '0;
  logic pixValid, pixEol, pixEof;
  logic [23:0] pixRgb;

  always #2.5 clk = ~clk;

  idxCursorPixelPath #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) dut_i (.*);

  // bench-side models
  logic [7:0]  vram [VMEM];
  logic [23:0] palM [256];
  logic [23:0] cpalM [3];
  logic [15:0] patM [512];

  always @(posedge clk) if (memRdEn) memRdData <= vram[memRdAddr % VMEM];

  int checks = 0, fails = 0, cyc = 0;
  int nPix = 0, nRd = 0, seenEof = 0;
  logic [23:0] outRgb [MAXPIX];
  logic outEol [MAXPIX];
  logic outEof [MAXPIX];
  int outCyc [MAXPIX];
  int rdAddr [MAXPIX];
  int rdCyc0 = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pixValid && nPix < MAXPIX) begin
      outRgb[nPix] = pixRgb; outEol[nPix] = pixEol; outEof[nPix] = pixEof;
      outCyc[nPix] = cyc; nPix = nPix + 1;
      if (pixEof) seenEof = seenEof + 1;
    end
    if (memRdEn && nRd < MAXPIX) begin
      if (nRd == 0) rdCyc0 = cyc;
      rdAddr[nRd] = int'(memRdAddr); nRd = nRd + 1;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    fails = fails + 1;
    $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
    summary();
  end

  task automatic chk(string req, int act, int exp, string what);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  function automatic logic [23:0] expPix(int x, int y, int w, int top, int cx, int cy,
                                         bit off, bit blank);
    logic [15:0] wd; int c;
    if (blank) return 24'h0;
    if (!off && x >= cx && x < cx + 64 && y >= cy && y < cy + 64) begin
      wd = patM[(y - cy) * 8 + (x - cx) / 8];
      c = (wd >> (2 * ((x - cx) % 8))) & 3;
      if (c != 0) return cpalM[c - 1];
    end
    return palM[vram[(top + y * w + x) % VMEM]];
  endfunction

  task automatic loadTables();
    for (int i = 0; i < 256; i++) begin
      palM[i] = {8'(i), 8'(~i), 8'(i ^ 8'h5a)};
      palWe = 1'b1; palIdx = 8'(i); palRgb = palM[i]; step();
    end
    palWe = 1'b0;
    cpalM[0] = 24'hff0000; cpalM[1] = 24'h00ff00; cpalM[2] = 24'h0000ff;
    for (int i = 0; i < 3; i++) begin
      cpalWe = 1'b1; cpalIdx = 2'(i); cpalRgb = cpalM[i]; step();
    end
    cpalWe = 1'b0;
    for (int i = 0; i < 512; i++) begin
      patM[i] = 16'(i * 16'h9e37 + 16'h1b4d);
      patWe = 1'b1; patIdx = 9'(i); patWord = patM[i]; step();
    end
    patWe = 1'b0;
  endtask

  // One frame: configure, start, optionally disturb mid-frame, compare all pixels.
  task automatic runFrame(string req, int w, int h, int top, int cx, int cy,
                          bit off, bit blank, bit disturb);
    int mis = 0, eolBad = 0, eofCnt = 0;
    nPix = 0; nRd = 0; seenEof = 0;
    cfgWidth = DIM_W'(w); cfgHeight = DIM_W'(h); cfgTop = ADDR_W'(top);
    cfgCursorPos = {12'(cx), 12'(cy)}; cfgCursorOff = off; cfgBlank = blank;
    frameGo = 1'b1; step(); frameGo = 1'b0;
    if (disturb) begin
      repeat (10) step();
      cfgWidth = 7; cfgHeight = 3; cfgTop = 0; cfgBlank = 1'b1; cfgCursorOff = 1'b0;
      frameGo = 1'b1; step(); frameGo = 1'b0;
    end
    for (int t = 0; t < 20000 && seenEof == 0; t++) step();
    repeat (4) step();
    chk(disturb ? "R11" : "R1", nPix, w * h, "pixel count");
    chk("R1", nRd, w * h, "read count");
    for (int i = 0; i < nRd && i < MAXPIX; i++)
      if (rdAddr[i] != top + i) mis = mis + 1;
    chk("R1", mis, 0, "read address mismatches");
    chk("R10", outCyc[0] - rdCyc0, 2, "first pixel latency");
    chk("R10", outCyc[nPix - 1] - outCyc[0], nPix - 1, "gapless span");
    for (int i = 0; i < nPix; i++) begin
      int x = i % w, y = i / w;
      checks = checks + 1;
      if (outRgb[i] !== expPix(x, y, w, top, cx, cy, off, blank)) begin
        fails = fails + 1;
        $display("FAIL %s pixel (%0d,%0d): actual 0x%06h expected 0x%06h", req, x, y,
                 outRgb[i], expPix(x, y, w, top, cx, cy, off, blank));
      end
      if (outEol[i] !== (x == w - 1)) eolBad = eolBad + 1;
      if (outEof[i]) eofCnt = eofCnt + 1;
    end
    chk("R3", eolBad, 0, "end-of-line misplacements");
    chk("R3", eofCnt, 1, "end-of-frame count");
    chk("R3", int'(outEof[nPix - 1]), 1, "end-of-frame on last pixel");
  endtask

  task automatic testReset();
    chk("R10", int'(pixValid), 0, "valid in reset");
    chk("R1", int'(memRdEn), 0, "read enable in reset");
  endtask

  task automatic testZero();
    nPix = 0; nRd = 0;
    cfgWidth = 0; cfgHeight = 5; frameGo = 1'b1; step(); frameGo = 1'b0;
    repeat (10) step();
    cfgWidth = 9; cfgHeight = 0; frameGo = 1'b1; step(); frameGo = 1'b0;
    repeat (10) step();
    chk("R4", nPix, 0, "pixels for zero size");
    chk("R4", nRd, 0, "reads for zero size");
  endtask

  initial begin
    for (int i = 0; i < VMEM; i++) vram[i] = 8'(i * 7 + 3);
    repeat (3) step();
    testReset();
    rstN = 1'b1; step();
    loadTables();
    runFrame("R2", 16, 4, 100, 0, 0, 1'b1, 1'b0, 1'b0);            // base colours
    runFrame("R7", 80, 70, 200, 4, 1, 1'b0, 1'b0, 1'b0);           // R5 R6 R7 cursor
    runFrame("R5", 80, 70, 37, 50, 40, 1'b0, 1'b0, 1'b0);          // R6 clipped cursor
    runFrame("R8", 80, 70, 200, 4, 1, 1'b1, 1'b0, 1'b0);           // cursor disabled
    runFrame("R9", 24, 6, 11, 0, 0, 1'b0, 1'b1, 1'b0);             // forced black
    testZero();
    runFrame("R11", 40, 5, 300, 2, 2, 1'b0, 1'b0, 1'b1);           // disturbed frame
    summary();
  end
endmodule